// File: doc/BRIEF.md
# Addressed Three-Wire Configuration Port

This block is the slave side of a configuration link that a host microcontroller drives over three wires: a serial clock, an active-low select, and a single data pin that both directions share. Up to four devices can sit on the same wires. Each one is told apart by a two-bit identity that is strapped at board level. Every frame carries an identity field, and a device acts on the frame only when that field equals its strap value.

A frame is 16 serial clocks long and is sent least significant bit first. Bits 0 and 1 are the identity, with bit 0 first. Bit 2 is the direction flag: 0 means write and 1 means read. Bits 3 to 7 are a five-bit register address, least significant bit first. Bits 8 to 15 are the data byte, least significant bit first.

A matching write frame updates one byte of an internal register bank when select rises. A matching read frame turns the data pin around after the eighth clock. The device then drives the addressed byte, least significant bit first, for the host to sample on clocks 9 through 16. The serial inputs are synchronised into the system clock domain. The register contents are presented on a flat output bus for the rest of the chip.

Top module: `three_wire_cfg`

## Requirements
- R1: While rst_ni is low, every register i of the bank holds the value 8'h10 + i. That is the value it shows right after reset.
- R2: A frame is a write when it is exactly 16 bits long, its identity equals id_i and its flag bit (bit 2) is 0. Such a frame stores bits 8 to 15 into the register named by bits 3 to 7. The store takes effect after select rises.
- R3: A frame whose identity bits differ from id_i changes no register and never drives the data pin. This holds for every strap value.
- R4: A write frame of any length other than 16 bits is discarded, whether it is shorter or longer.
- R5: For a matching read frame (flag bit 1), sdio_o carries the addressed byte on serial clocks 9 to 16, bit 0 first. The host samples each bit on the rising edge.
- R6: sdio_oe_o is high only during the data clocks of a matching read. It is low whenever csn_i is high.
- R7: Serial clock and data activity while csn_i is high has no effect on any register or on the next frame.
- R8: Addresses at or above NUM_REGS (default 8) are not stored. A read of such an address returns 8'h00.
- R9: Raising select at any bit count resets the bit counter, so the next frame starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_i | input | 2 | Strapped device identity |
| sclk_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Data pin, input side |
| sdio_o | output | 1 | Data pin, output side |
| sdio_oe_o | output | 1 | Data pin output enable |
| regs_o | output | NUM_REGS*8 | Register bank contents, register i at bits 8i+7:8i |

## Verification
Every serial event reaches the core through a two-stage synchroniser and then an edge detector. A write therefore shows on regs_o about three system clocks after select rises. Read data appears about three clocks after the eighth serial rising edge.

The bench holds each serial clock phase for 8 system clocks. It samples sdio_o at the host's rising edge, so the driven bit has long been stable. It updates its register model and resumes the per-clock register compare only 12 clocks after select rises, which is past the write latency. The release of the output enable follows csn_i combinationally, so that check runs on every clock with no allowance.

// File: rtl/three_wire_cfg_pkg.sv
package three_wire_cfg_pkg;
  localparam int ID_W      = 2;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam int HDR_BITS  = ID_W + 1 + ADDR_W;
  localparam int FRAME_LEN = HDR_BITS + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);

  function automatic logic [DATA_W-1:0] cfg_reset(input int idx);
    return DATA_W'(8'h10 + idx);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import three_wire_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              csn_s_i,
  input  logic              sdi_s_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              oe_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_LEN + 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [FRAME_LEN-1:0] sr_q;
  logic [DATA_W-1:0]    tx_q;
  logic                 csn_q, oe_q;
  logic [HDR_BITS-1:0]  hdr_nxt;
  logic                 csn_rise;

  // header as it stands once the current bit is in
  assign hdr_nxt   = {sdi_s_i, sr_q[FRAME_LEN-1 -: HDR_BITS-1]};
  assign rd_addr_o = hdr_nxt[HDR_BITS-1 -: ADDR_W];
  assign csn_rise  = csn_s_i & ~csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
      tx_q  <= '0;
      csn_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      csn_q <= csn_s_i;
      if (csn_s_i) begin
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (sclk_rise_i) begin
        sr_q <= {sdi_s_i, sr_q[FRAME_LEN-1:1]};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_HDR) begin
          oe_q <= (hdr_nxt[ID_W-1:0] == id_i) & hdr_nxt[ID_W];
          tx_q <= rd_data_i;
        end else if (cnt_q > CNT_HDR && cnt_q < CNT_LAST) begin
          tx_q <= tx_q >> 1;
        end else if (cnt_q == CNT_LAST) begin
          oe_q <= 1'b0;
        end
      end
    end
  end

  assign wr_en_o   = csn_rise && (cnt_q == CNT_FULL) &&
                     (sr_q[ID_W-1:0] == id_i) && !sr_q[ID_W];
  assign wr_addr_o = sr_q[HDR_BITS-1 -: ADDR_W];
  assign wr_data_o = sr_q[FRAME_LEN-1 -: DATA_W];
  assign sdo_o     = tx_q[0];
  assign oe_o      = oe_q;
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import three_wire_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= cfg_reset(i);
      else if (wr_en_i && wr_addr_i == ADDR_W'(i)) regs_q[i] <= wr_data_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = regs_q[i];
  end

  assign rd_data_o = (rd_addr_i < LIMIT) ? regs_q[rd_addr_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/three_wire_cfg.sv
module three_wire_cfg
  import three_wire_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 id_i,
  input  logic                       sclk_i,
  input  logic                       csn_i,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  output logic [NUM_REGS*8-1:0]      regs_o
);
  localparam logic [2:0] SYNC_RST = 3'b010;

  logic [2:0] raw_in, sync_out;
  logic       sclk_s, csn_s, sdi_s, sclk_q, sclk_rise;
  logic       wr_en, oe_q;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [CNT_W-1:0]  bit_cnt;

  assign raw_in = {sdio_i, csn_i, sclk_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    cfg_sync #(.STAGES(2), .RST_VAL(SYNC_RST[g])) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in[g]),
      .q_o   (sync_out[g])
    );
  end

  assign sclk_s = sync_out[0];
  assign csn_s  = sync_out[1];
  assign sdi_s  = sync_out[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_q;

  cfg_frame_rx i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_rise_i(sclk_rise),
    .csn_s_i    (csn_s),
    .sdi_s_i    (sdi_s),
    .id_i       (id_i),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .sdo_o      (sdio_o),
    .oe_o       (oe_q),
    .bit_cnt_o  (bit_cnt)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );

  // release the pin as soon as select goes high
  assign sdio_oe_o = oe_q & ~csn_i;
endmodule

// File: rtl/three_wire_cfg_chk.sv
module three_wire_cfg_chk
  import three_wire_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       csn_s,
  input logic                       oe_q,
  input logic                       wr_en,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic [NUM_REGS*8-1:0]      regs_o
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] HI = CNT_W'(FRAME_LEN);

  assert_oe_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (bit_cnt >= LO && bit_cnt < HI));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_s && $past(csn_s) && !wr_en) |=> $stable(regs_o));

  assert_write_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_o));

  assert_cnt_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> (bit_cnt == '0));

  assert_oe_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> !oe_q);
endmodule

bind three_wire_cfg three_wire_cfg_chk #(.NUM_REGS(NUM_REGS)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .csn_s  (csn_s),
  .oe_q   (oe_q),
  .wr_en  (wr_en),
  .bit_cnt(bit_cnt),
  .regs_o (regs_o)
);

// File: tb/test_three_wire_cfg.sv
`timescale 1ns/1ps
module test_three_wire_cfg;
  localparam int NUM_REGS = 8;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] id = 2'd2;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic sdo, oe;
  logic [NUM_REGS*8-1:0] regs;

  int n_chk = 0, n_fail = 0;
  int mdl [NUM_REGS];
  bit settled = 0, done = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  three_wire_cfg #(.NUM_REGS(NUM_REGS)) i_three_wire_cfg (
    .clk_i(clk), .rst_ni(rst_ni), .id_i(id), .sclk_i(sclk), .csn_i(csn),
    .sdio_i(sdi), .sdio_o(sdo), .sdio_oe_o(oe), .regs_o(regs));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_ni && !done) begin
    if (csn) chk(oe == 1'b0, "R6 oe while select high", oe, 0);
    if (settled)
      for (int i = 0; i < NUM_REGS; i++)
        chk(regs[i*8 +: 8] == 8'(mdl[i]), "R2 register model", regs[i*8 +: 8], mdl[i]);
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] fid, input logic rw, input logic [4:0] addr,
                       input logic [7:0] data, input int nbits, output logic [7:0] rdata);
    logic [15:0] fr;
    bit rd_match;
    fr = {data, addr, rw, fid};
    rd_match = (fid == id) && rw;
    rdata = '0;
    settled = 0;
    csn = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < nbits; k++) begin
      sdi = (k < 16) ? fr[k] : 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
      if (k >= 8 && k < 16) begin
        rdata[k-8] = sdo;
        chk(oe == rd_match, "R6 oe in data phase", oe, rd_match);
      end
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(12);
    if (nbits == 16 && fid == id && !rw && addr < NUM_REGS) mdl[addr] = data;
    settled = 1;
  endtask

  task automatic check_read(input logic [4:0] addr, input string req);
    int exp;
    exp = (addr < NUM_REGS) ? mdl[addr] : 0;
    frame(id, 1'b1, addr, 8'h00, 16, rd);
    chk(rd == 8'(exp), req, rd, exp);
  endtask

  initial begin
    for (int i = 0; i < NUM_REGS; i++) mdl[i] = 16 + i;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(4);
    // R1 reset values
    for (int i = 0; i < NUM_REGS; i++)
      chk(regs[i*8 +: 8] == 8'(16 + i), "R1 reset value", regs[i*8 +: 8], 16 + i);
    settled = 1;

    frame(2'd2, 1'b0, 5'd3, 8'hA5, 16, rd);            // R2
    chk(regs[3*8 +: 8] == 8'hA5, "R2 write stored", regs[3*8 +: 8], 8'hA5);
    check_read(5'd3, "R5 read back written");
    check_read(5'd7, "R5 read reset value");
    frame(2'd2, 1'b0, 5'd7, 8'h3C, 16, rd);
    check_read(5'd7, "R5 read after second write");

    frame(2'd1, 1'b0, 5'd0, 8'hFF, 16, rd);            // R3 mismatch write
    chk(regs[7:0] == 8'h10, "R3 mismatch write ignored", regs[7:0], 8'h10);
    frame(2'd0, 1'b1, 5'd3, 8'h00, 16, rd);            // R3 mismatch read, oe checked in task

    frame(2'd2, 1'b0, 5'd1, 8'h77, 15, rd);            // R4 short
    chk(regs[15:8] == 8'h11, "R4 short frame discarded", regs[15:8], 8'h11);
    frame(2'd2, 1'b0, 5'd1, 8'h77, 17, rd);            // R4 long
    chk(regs[15:8] == 8'h11, "R4 long frame discarded", regs[15:8], 8'h11);

    // R7 activity while select high
    for (int k = 0; k < 10; k++) begin
      sdi = k[0]; sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
    end
    frame(2'd2, 1'b0, 5'd2, 8'h5A, 16, rd);
    chk(regs[23:16] == 8'h5A, "R7 frame after idle clocks", regs[23:16], 8'h5A);

    frame(2'd2, 1'b0, 5'd4, 8'hEE, 5, rd);             // R9 aborted frame
    frame(2'd2, 1'b0, 5'd4, 8'hC3, 16, rd);
    chk(regs[39:32] == 8'hC3, "R9 counter restarted", regs[39:32], 8'hC3);

    frame(2'd2, 1'b0, 5'd20, 8'h99, 16, rd);           // R8
    check_read(5'd20, "R8 out-of-range read zero");
    check_read(5'd4, "R8 in-range unaffected");

    id = 2'd1;                                          // R3 another strap
    wait_clk(4);
    frame(2'd1, 1'b0, 5'd6, 8'h81, 16, rd);
    chk(regs[55:48] == 8'h81, "R3 new strap write", regs[55:48], 8'h81);
    frame(2'd2, 1'b0, 5'd6, 8'h00, 16, rd);
    chk(regs[55:48] == 8'h81, "R3 old id ignored", regs[55:48], 8'h81);
    check_read(5'd6, "R5 read with new strap");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule